// File: doc/BRIEF.md
# Prefix-Extended Instruction Fetch and Operand Decoder

This block is the front end of a small 8-bit stack processor. It holds the program counter and presents it as an address to a separate 256-byte program memory. That memory returns the addressed byte combinationally. Each byte is one instruction: a 4-bit function code in the upper nibble and a 4-bit immediate nibble in the lower one.

Two prefix functions build operands wider than one nibble. One prefix shifts the value it has gathered so far. The other shifts its complement. Both keep the gathered value in an operand register and issue nothing. Any other function issues one decoded item, and the operand register then starts again from zero. The function code 0xF selects the extended instruction space. For that code the full 8-bit operand is the number of the extended operation.

A downstream ready input decides whether a byte is consumed in a given cycle. A jump strobe reloads the program counter at any time, and the block takes care of the partial operand that is left behind.

Top module: `nibop_frontend`

## Requirements
- R1: An instruction byte carries the function code in bits [7:4] and the immediate nibble in bits [3:0]. Function 0x2 is the positive prefix, 0x6 is the negative prefix, and every other code is a plain function.
- R2: A consumed positive prefix sets the operand register to ((oreg | nibble) << 4), truncated to 8 bits.
- R3: A consumed negative prefix sets the operand register to ((~(oreg | nibble)) << 4), truncated to 8 bits.
- R4: A consumed plain function issues that function code with operand (oreg | nibble). The operand register is zero afterwards.
- R5: A consumed prefix byte produces no issued item.
- R6: `dec_ext` is 1 on an issued item exactly when its function code is 0xF. The operand then carries the extended operation number. On every other issued item `dec_ext` is 0.
- R7: Each consumed byte advances the program counter by one, and the counter wraps from 0xFF to 0x00. A partial operand carries across the wrap.
- R8: While `dec_ready` is low and no jump is requested, no byte is consumed, the address holds, and `dec_valid` is low in the next cycle.
- R9: `jmp_load` places `jmp_target` on `imem_addr` at the next edge, whether or not `dec_ready` is high. The byte addressed in that cycle is discarded without issue, and the operand register is cleared.
- R10: `dec_valid` is high for exactly the cycle that follows the edge that consumed a plain function. The decoded fields are held in registers.
- R11: A synchronous active-high reset sets the address to 0x00, clears the operand register and holds `dec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_ready | input | 1 | Downstream can accept; a byte is consumed in this cycle |
| jmp_load | input | 1 | Load the program counter from `jmp_target` |
| jmp_target | input | 8 | Jump destination address |
| imem_addr | output | 8 | Program memory address (program counter) |
| imem_rdata | input | 8 | Program byte at `imem_addr`, combinational |
| dec_valid | output | 1 | One-cycle strobe for an issued item |
| dec_func | output | 4 | Issued function code |
| dec_operand | output | 8 | Issued full operand or extended operation number |
| dec_ext | output | 1 | Issued item selects the extended space |

## Verification
A byte is consumed on the rising edge of a cycle in which `dec_ready` is high. Its issued item shows up on the outputs right after that edge. The bench drives inputs on the falling edge, so it pushes the expected item into the scoreboard before the consuming edge, and the monitor pops and compares on the next falling edge. The program counter changes at the same edge that consumes a byte or applies a jump. The bench therefore compares `imem_addr` with its model on the following falling edge, and it does the same during stall windows, where neither the address nor `dec_valid` may move.

// File: rtl/nibop_pkg.sv
package nibop_pkg;

    localparam int NIB_W  = 4;
    localparam int WORD_W = 2 * NIB_W;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam nib_t FN_PFIX = 4'h2;
    localparam nib_t FN_NFIX = 4'h6;
    localparam nib_t FN_OPR  = 4'hF;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_PFIX  = 2'd1,
        K_NFIX  = 2'd2
    } kind_t;

    typedef struct packed {
        nib_t func;
        nib_t nib;
    } instr_t;

    typedef struct packed {
        nib_t  func;
        word_t operand;
        logic  ext;
    } issue_t;

    function automatic kind_t classify(input nib_t f);
        if (f == FN_PFIX)      return K_PFIX;
        else if (f == FN_NFIX) return K_NFIX;
        else                   return K_PLAIN;
    endfunction

    function automatic word_t widen(input nib_t n);
        return {{(WORD_W-NIB_W){1'b0}}, n};
    endfunction

    function automatic word_t prefix_step(input word_t comb, input logic negate);
        word_t base;
        base = negate ? ~comb : comb;
        return base << NIB_W;
    endfunction

endpackage

// File: rtl/nibop_pc.sv
module nibop_pc #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);
    localparam logic [ADDR_W-1:0] PC_ONE   = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] PC_RESET = '0;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    // Jump has priority over the sequential step; the sum wraps naturally.
    always_comb begin
        pc_d = pc_q;
        if (load)
            pc_d = target;
        else if (advance)
            pc_d = pc_q + PC_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= PC_RESET;
        else
            pc_q <= pc_d;
    end

    assign pc = pc_q;

endmodule

// File: rtl/nibop_oreg.sv
module nibop_oreg
    import nibop_pkg::*;
#(
    parameter bit NEG_PREFIX_EN = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    input  logic   flush,
    input  instr_t instr,
    output kind_t  kind,
    output word_t  operand
);
    word_t oreg_q;
    word_t oreg_d;
    word_t comb_val;
    word_t after_pfix;
    word_t after_nfix;
    kind_t kind_raw;

    assign kind_raw   = classify(instr.func);
    assign comb_val   = oreg_q | widen(instr.nib);
    assign after_pfix = prefix_step(comb_val, 1'b0);

    // The complementing prefix can be configured out; it then acts as a plain function.
    generate
        if (NEG_PREFIX_EN) begin : g_neg
            assign after_nfix = prefix_step(comb_val, 1'b1);
            assign kind       = kind_raw;
        end else begin : g_no_neg
            assign after_nfix = '0;
            assign kind       = (kind_raw == K_NFIX) ? K_PLAIN : kind_raw;
        end
    endgenerate

    always_comb begin
        oreg_d = oreg_q;
        if (flush) begin
            oreg_d = '0;
        end else if (advance) begin
            unique case (kind)
                K_PFIX:  oreg_d = after_pfix;
                K_NFIX:  oreg_d = after_nfix;
                default: oreg_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            oreg_q <= '0;
        else
            oreg_q <= oreg_d;
    end

    assign operand = comb_val;

endmodule

// File: rtl/nibop_issue.sv
module nibop_issue
    import nibop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  issue_t item_in,
    output logic   valid,
    output issue_t item_out
);
    logic   valid_q;
    issue_t item_q;

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else
            valid_q <= fire;
    end

    // The payload is loaded only when an item fires, so it holds between strobes.
    always_ff @(posedge clk) begin
        if (rst)
            item_q <= '0;
        else if (fire)
            item_q <= item_in;
    end

    assign valid    = valid_q;
    assign item_out = item_q;

endmodule

// File: rtl/nibop_frontend.sv
module nibop_frontend
    import nibop_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter bit NEG_PREFIX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_ready,
    input  logic              jmp_load,
    input  logic [ADDR_W-1:0] jmp_target,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic              dec_valid,
    output logic [NIB_W-1:0]  dec_func,
    output logic [WORD_W-1:0] dec_operand,
    output logic              dec_ext
);
    instr_t cur_instr;
    kind_t  cur_kind;
    word_t  cur_operand;
    logic   advance;
    logic   fire;
    issue_t next_item;
    issue_t held_item;

    assign cur_instr = instr_t'(imem_rdata);

    // A pending jump discards the byte in flight instead of consuming it.
    assign advance = dec_ready && !jmp_load;

    nibop_pc #(
        .ADDR_W (ADDR_W)
    ) pc_i (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .load    (jmp_load),
        .target  (jmp_target),
        .pc      (imem_addr)
    );

    nibop_oreg #(
        .NEG_PREFIX_EN (NEG_PREFIX_EN)
    ) oreg_i (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .flush   (jmp_load),
        .instr   (cur_instr),
        .kind    (cur_kind),
        .operand (cur_operand)
    );

    assign fire              = advance && (cur_kind == K_PLAIN);
    assign next_item.func    = cur_instr.func;
    assign next_item.operand = cur_operand;
    assign next_item.ext     = (cur_instr.func == FN_OPR);

    nibop_issue issue_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .item_in  (next_item),
        .valid    (dec_valid),
        .item_out (held_item)
    );

    assign dec_func    = held_item.func;
    assign dec_operand = held_item.operand;
    assign dec_ext     = held_item.ext;

endmodule

// File: rtl/nibop_frontend_chk.sv
module nibop_frontend_chk
    import nibop_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dec_ready,
    input logic              jmp_load,
    input logic [ADDR_W-1:0] jmp_target,
    input logic [ADDR_W-1:0] imem_addr,
    input logic [WORD_W-1:0] imem_rdata,
    input logic              dec_valid,
    input logic [NIB_W-1:0]  dec_func,
    input logic [WORD_W-1:0] dec_operand,
    input logic              dec_ext
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // R11: reset leaves address zero and no strobe
    p_reset_state_r11: assert property (@(posedge clk)
        rst |=> (!dec_valid && imem_addr == '0));

    // R7: a consumed byte steps the address by one, with wrap
    p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_ready && !jmp_load) |=> imem_addr == $past(imem_addr) + ONE);

    // R8: a stall holds the address and gives no strobe
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!dec_ready && !jmp_load) |=> (imem_addr == $past(imem_addr) && !dec_valid));

    // R9: a jump loads the target and issues nothing
    p_jump_load_r9: assert property (@(posedge clk) disable iff (rst)
        jmp_load |=> (imem_addr == $past(jmp_target) && !dec_valid));

    // R5: a consumed prefix byte gives no strobe
    p_prefix_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_ready && !jmp_load &&
         (imem_rdata[7:4] == FN_PFIX || imem_rdata[7:4] == FN_NFIX)) |=> !dec_valid);

    // R10: a consumed plain byte gives a strobe at the next edge
    p_plain_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (dec_ready && !jmp_load &&
         imem_rdata[7:4] != FN_PFIX && imem_rdata[7:4] != FN_NFIX) |=>
        (dec_valid && dec_func == $past(imem_rdata[7:4])));

    // R6: the extended flag is raised only for the operate code
    p_ext_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ext) |-> dec_func == FN_OPR);

endmodule

bind nibop_frontend nibop_frontend_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/nibop_frontend_tb_top.sv
module nibop_frontend_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_ready = 1'b0;
    logic       jmp_load = 1'b0;
    logic [7:0] jmp_target = 8'h00;
    logic [7:0] imem_addr;
    logic [7:0] imem_rdata;
    logic       dec_valid;
    logic [3:0] dec_func;
    logic [7:0] dec_operand;
    logic       dec_ext;

    logic [7:0]  prog [256];
    logic [12:0] exp_q [$];
    logic [7:0]  m_pc;
    logic [7:0]  m_oreg;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_rdata = prog[imem_addr];

    nibop_frontend dut_i (
        .clk         (clk),
        .rst         (rst),
        .dec_ready   (dec_ready),
        .jmp_load    (jmp_load),
        .jmp_target  (jmp_target),
        .imem_addr   (imem_addr),
        .imem_rdata  (imem_rdata),
        .dec_valid   (dec_valid),
        .dec_func    (dec_func),
        .dec_operand (dec_operand),
        .dec_ext     (dec_ext)
    );

    task automatic check(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Reference model of one consumed byte, written from R1..R4 and R6, R7
    task automatic model_consume();
        logic [7:0] b;
        logic [3:0] f;
        logic [7:0] comb;
        b    = prog[m_pc];
        f    = b[7:4];
        comb = m_oreg | {4'h0, b[3:0]};
        if (f == 4'h2) begin
            m_oreg = comb << 4;          // R2
        end else if (f == 4'h6) begin
            m_oreg = (~comb) << 4;       // R3
        end else begin
            exp_q.push_back({f, comb, f == 4'hF});  // R4 R6
            m_oreg = 8'h00;
        end
        m_pc = m_pc + 8'd1;              // R7
    endtask

    // Consume n bytes, holding ready low for (i % gap) cycles after each.
    task automatic run_bytes(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            model_consume();
            dec_ready = 1'b1;
            @(negedge clk);
            dec_ready = 1'b0;
            if (gap > 0) begin
                for (int k = 0; k < (i % gap); k++) @(negedge clk);
            end
        end
        @(negedge clk);
    endtask

    task automatic jump_to(input logic [7:0] t, input bit rdy);
        jmp_load   = 1'b1;
        jmp_target = t;
        dec_ready  = rdy;
        m_pc       = t;
        m_oreg     = 8'h00;              // R9
        @(negedge clk);
        jmp_load   = 1'b0;
        dec_ready  = 1'b0;
        check(dec_valid == 1'b0, "R9 jump issued an item", {15'd0, dec_valid}, 16'd0);
        check(imem_addr == t, "R9 jump address", {8'd0, imem_addr}, {8'd0, t});
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R10 unexpected issue", {3'd0, dec_func, dec_operand, dec_ext}, 16'd0);
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                check({dec_func, dec_operand, dec_ext} == e, "R4/R6 issued item",
                      {3'd0, dec_func, dec_operand, dec_ext}, {3'd0, e});
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) prog[i] = 8'(i * 37 + 11);
        // R1 directed prefix chains
        prog[0]  = 8'h2A; prog[1]  = 8'h13;   // A3
        prog[2]  = 8'h60; prog[3]  = 8'h45;   // F5
        prog[4]  = 8'h2F; prog[5]  = 8'h2F; prog[6] = 8'h00;
        prog[7]  = 8'hF7;                     // ext 07
        prog[8]  = 8'h2B; prog[9]  = 8'hF1;   // ext B1
        prog[10] = 8'h61; prog[11] = 8'h62; prog[12] = 8'h83;
        prog[8'h40] = 8'h5C;
        prog[8'hFE] = 8'h61; prog[8'hFF] = 8'h2C;
        m_pc = 8'h00; m_oreg = 8'h00;

        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0, "R11 valid after reset", {15'd0, dec_valid}, 16'd0);
        check(imem_addr == 8'h00, "R11 address after reset", {8'd0, imem_addr}, 16'd0);
        rst = 1'b0;
        @(negedge clk);

        // Directed chains, back-to-back (R2 R3 R4 R6)
        run_bytes(13, 0);
        check(imem_addr == m_pc, "R7 address after chains", {8'd0, imem_addr}, {8'd0, m_pc});

        // Stall window: nothing moves (R8)
        repeat (3) begin
            @(negedge clk);
            check(dec_valid == 1'b0, "R8 strobe during stall", {15'd0, dec_valid}, 16'd0);
            check(imem_addr == m_pc, "R8 address during stall", {8'd0, imem_addr}, {8'd0, m_pc});
        end

        // Computed pattern region with irregular stalls (R5 R10)
        run_bytes(60, 3);
        check(imem_addr == m_pc, "R7 address after pattern", {8'd0, imem_addr}, {8'd0, m_pc});

        // Jump while stalled after a pending prefix (R9)
        jump_to(8'h00, 1'b1);
        run_bytes(1, 0);                      // consumes PFIX A
        jump_to(8'h40, 1'b0);
        run_bytes(1, 0);                      // 5C with no stale prefix
        // Jump with ready high discards the current byte
        jump_to(8'h0A, 1'b1);
        run_bytes(3, 2);

        // Wrap across 0xFF with a carried operand (R7)
        jump_to(8'hFE, 1'b0);
        run_bytes(4, 1);
        check(imem_addr == 8'h02, "R7 wrapped address", {8'd0, imem_addr}, 16'h0002);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R10 missing issues", 16'(exp_q.size()), 16'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule